// File: doc/BRIEF.md
# Atomic Bus Lock Controller

This block reserves the system bus for one master while that master carries out a two-step sequence against a memory bank set up for atomic use. Each bank carries a 2-bit atomic-mode field. One ordering sets the lock on a write and clears it on a later read. The opposite ordering sets the lock on a read and clears it on a later write. While the lock is held, `busLock` tells the arbiter to grant only the master shown on `ownerId`.

The block watches completed accesses. Each one is described by the mode of the bank it hits, a hit flag, the direction and the ID of the master. A built-in watchdog removes a lock that its owner never clears, 256 cycles after the lock was taken, and marks that event with a one-cycle pulse. Arbitration, address decoding and the data path are handled outside this block.

Top module: `atomic_lock_top`

## Requirements
- R1: While `rstN` is low, `busLock`, `ownerId`, `lockTimeout` and the watchdog count are all zero. `ownerId` reads zero whenever `busLock` is low.
- R2: Mode 2'b01 sets the lock on a completed write. When `busLock` is low and a cycle has `accDone`=1, `bankHit`=1, `isWrite`=1 and `atomMode`=2'b01, then `busLock`=1 and `ownerId`=`masterId` from the next cycle on.
- R3: A lock taken in mode 2'b01 is cleared by a completed read (`isWrite`=0) from the owner with `bankHit`=1. `busLock` is low from the next cycle on.
- R4: Mode 2'b10 sets the lock on a completed read. A completed read with `bankHit`=1 and `atomMode`=2'b10 sets `busLock` and `ownerId` from the next cycle on.
- R5: A lock taken in mode 2'b10 is cleared by a completed write from the owner with `bankHit`=1, in the next cycle.
- R6: Some inputs never set the lock: `atomMode` 2'b00 or 2'b11, a cycle with `accDone`=0, or a cycle with `bankHit`=0.
- R7: While locked, an access from a master other than the owner changes neither `busLock` nor `ownerId`. The same holds for an owner access in the direction that sets the lock, and for an owner access with `bankHit`=0.
- R8: A lock that is never cleared stays high for exactly 256 cycles and then drops. `lockTimeout` is high for exactly one cycle, the first cycle in which `busLock` is low again.
- R9: If the owner's clearing access completes in the last (256th) locked cycle, the lock drops with no `lockTimeout` pulse.
- R10: An access that would set the lock has no effect in a cycle where the lock is still held, including the cycle where the watchdog expires. The same access in the following cycle does set the lock.
- R11: Which direction clears the lock is fixed by the mode captured when the lock was taken. The value of `atomMode` at the clearing access does not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| atomMode | input | 2 | Atomic-mode field of the bank being accessed |
| bankHit | input | 1 | Access targets the atomic bank |
| isWrite | input | 1 | Direction of the access: 1 write, 0 read |
| accDone | input | 1 | The access completes this cycle |
| masterId | input | ID_W | ID of the master performing the access |
| busLock | output | 1 | Bus is reserved for `ownerId` |
| ownerId | output | ID_W | ID of the master holding the lock, zero when free |
| lockTimeout | output | 1 | One-cycle pulse after a watchdog release |

## Verification
Every result here passes through exactly one register. An access sampled at one rising edge shows on `busLock` and `ownerId` in the cycle that follows. The watchdog release and its `lockTimeout` pulse appear together, 256 cycles after the lock appeared. Inputs are driven just after the falling edge, and a reference model in the bench advances on the rising edge. Outputs are compared at each falling edge, so every comparison falls one full register stage after its stimulus. The directed watchdog cases count idle drives so that the clearing or competing access lands exactly in the 256th locked cycle.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;

  typedef enum logic [1:0] {
    ATOM_OFF = 2'b00,
    ATOM_RAW = 2'b01,
    ATOM_WAR = 2'b10,
    ATOM_RSV = 2'b11
  } atomMode_e;

  typedef struct packed {
    logic takeLock;
    logic ownerRelease;
    logic forceRelease;
  } lockStrobe_t;

endpackage

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl
  import atomic_lock_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [1:0]      atomMode,
  input  logic            bankHit,
  input  logic            isWrite,
  input  logic            accDone,
  input  logic [ID_W-1:0] masterId,
  input  logic            locked,
  input  logic [ID_W-1:0] ownerId,
  input  atomMode_e       heldMode,
  input  logic            wdExpired,
  output lockStrobe_t     strobe
);

  logic validAcc;
  logic lockingAcc;
  logic ownerAcc;
  logic unlockDir;

  assign validAcc = accDone && bankHit;

  // the direction that sets a lock depends on the bank's current mode
  always_comb begin
    unique case (atomMode_e'(atomMode))
      ATOM_RAW: lockingAcc = isWrite;
      ATOM_WAR: lockingAcc = !isWrite;
      default:  lockingAcc = 1'b0;
    endcase
  end

  // the direction that clears a lock depends on the mode captured at lock time
  assign unlockDir = (heldMode == ATOM_RAW) ? !isWrite : isWrite;
  assign ownerAcc  = validAcc && (masterId == ownerId);

  always_comb begin
    strobe              = '0;
    strobe.takeLock     = !locked && validAcc && lockingAcc;
    strobe.ownerRelease = locked && ownerAcc && unlockDir;
    strobe.forceRelease = locked && wdExpired && !strobe.ownerRelease;
  end

endmodule

// File: rtl/atomic_lock_dp.sv
module atomic_lock_dp
  import atomic_lock_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int WD_LIMIT = 256
) (
  input  logic            clk,
  input  logic            rstN,
  input  lockStrobe_t     strobe,
  input  logic [1:0]      atomMode,
  input  logic [ID_W-1:0] masterId,
  output logic            locked,
  output logic [ID_W-1:0] ownerId,
  output atomMode_e       heldMode,
  output logic            wdExpired,
  output logic            lockTimeout
);

  localparam int CNT_W = (WD_LIMIT > 2) ? $clog2(WD_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WD_LIMIT - 1);

  logic [CNT_W-1:0] wdCnt;

  assign wdExpired = (wdCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked      <= 1'b0;
      ownerId     <= '0;
      heldMode    <= ATOM_OFF;
      wdCnt       <= '0;
      lockTimeout <= 1'b0;
    end else begin
      lockTimeout <= strobe.forceRelease;
      if (strobe.takeLock) begin
        locked   <= 1'b1;
        ownerId  <= masterId;
        heldMode <= atomMode_e'(atomMode);
        wdCnt    <= '0;
      end else if (strobe.ownerRelease || strobe.forceRelease) begin
        locked   <= 1'b0;
        ownerId  <= '0;
        heldMode <= ATOM_OFF;
        wdCnt    <= '0;
      end else if (locked) begin
        wdCnt <= wdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/atomic_lock_top.sv
module atomic_lock_top
  import atomic_lock_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int WD_LIMIT = 256
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      atomMode,
  input  logic            bankHit,
  input  logic            isWrite,
  input  logic            accDone,
  input  logic [ID_W-1:0] masterId,
  output logic            busLock,
  output logic [ID_W-1:0] ownerId,
  output logic            lockTimeout
);

  lockStrobe_t     strobe;
  logic            locked;
  logic [ID_W-1:0] curOwner;
  atomMode_e       heldMode;
  logic            wdExpired;

  atomic_lock_ctrl #(.ID_W(ID_W)) ctrl_i (
    .atomMode  (atomMode),
    .bankHit   (bankHit),
    .isWrite   (isWrite),
    .accDone   (accDone),
    .masterId  (masterId),
    .locked    (locked),
    .ownerId   (curOwner),
    .heldMode  (heldMode),
    .wdExpired (wdExpired),
    .strobe    (strobe)
  );

  atomic_lock_dp #(.ID_W(ID_W), .WD_LIMIT(WD_LIMIT)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .atomMode    (atomMode),
    .masterId    (masterId),
    .locked      (locked),
    .ownerId     (curOwner),
    .heldMode    (heldMode),
    .wdExpired   (wdExpired),
    .lockTimeout (lockTimeout)
  );

  assign busLock = locked;
  assign ownerId = curOwner;

endmodule

// File: rtl/atomic_lock_chk.sv
module atomic_lock_chk #(
  parameter int ID_W     = 4,
  parameter int WD_LIMIT = 256
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      atomMode,
  input logic            bankHit,
  input logic            accDone,
  input logic            busLock,
  input logic [ID_W-1:0] ownerId,
  input logic            lockTimeout
);

  localparam int HC_W = $clog2(WD_LIMIT + 2) + 1;

  logic [HC_W-1:0] heldCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        heldCnt <= '0;
    else if (busLock) heldCnt <= heldCnt + 1'b1;
    else              heldCnt <= '0;
  end

  // R1
  owner_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busLock |-> (ownerId == '0));

  // R7
  owner_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busLock && $past(busLock)) |-> $stable(ownerId));

  // R6
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLock) |-> $past(accDone && bankHit && (atomMode == 2'b01 || atomMode == 2'b10)));

  // R8
  lock_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> (heldCnt < HC_W'(WD_LIMIT)));

  // R8
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockTimeout |-> ($fell(busLock) && $past(heldCnt) == HC_W'(WD_LIMIT - 1)));

endmodule

bind atomic_lock_top atomic_lock_chk #(.ID_W(ID_W), .WD_LIMIT(WD_LIMIT)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .atomMode    (atomMode),
  .bankHit     (bankHit),
  .accDone     (accDone),
  .busLock     (busLock),
  .ownerId     (ownerId),
  .lockTimeout (lockTimeout)
);

// File: tb/atomic_lock_tb.sv
`timescale 1ns/1ps
module atomic_lock_top_tb_top;

  localparam int ID_W = 4;
  localparam int WD   = 256;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      atomMode = 2'b00;
  logic            bankHit = 1'b0;
  logic            isWrite = 1'b0;
  logic            accDone = 1'b0;
  logic [ID_W-1:0] masterId = '0;
  logic            busLock;
  logic [ID_W-1:0] ownerId;
  logic            lockTimeout;

  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 1'b0;
  bit    cmpOn = 1'b0;
  string curTag = "R1";

  // reference model state
  logic            mLocked;
  logic [ID_W-1:0] mOwner;
  logic [1:0]      mMode;
  int              mCnt;
  logic            mTo;

  always #2.5 clk = ~clk;

  atomic_lock_top #(.ID_W(ID_W), .WD_LIMIT(WD)) dut_i (
    .clk(clk), .rstN(rstN), .atomMode(atomMode), .bankHit(bankHit),
    .isWrite(isWrite), .accDone(accDone), .masterId(masterId),
    .busLock(busLock), .ownerId(ownerId), .lockTimeout(lockTimeout)
  );

  function automatic logic locksOn(input logic [1:0] m, input logic w);
    return (m == 2'b01 && w) || (m == 2'b10 && !w);
  endfunction

  function automatic logic clearsOn(input logic [1:0] held, input logic w);
    return (held == 2'b01) ? !w : w;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLocked <= 1'b0; mOwner <= '0; mMode <= 2'b00; mCnt <= 0; mTo <= 1'b0;
    end else begin
      logic relOwn, expire, take;
      relOwn = mLocked && accDone && bankHit && masterId == mOwner && clearsOn(mMode, isWrite);
      expire = mLocked && mCnt == WD - 1;
      take   = !mLocked && accDone && bankHit && locksOn(atomMode, isWrite);
      mTo <= expire && !relOwn;
      if (take) begin
        mLocked <= 1'b1; mOwner <= masterId; mMode <= atomMode; mCnt <= 0;
      end else if (relOwn || expire) begin
        mLocked <= 1'b0; mOwner <= '0; mMode <= 2'b00; mCnt <= 0;
      end else if (mLocked) begin
        mCnt <= mCnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN && !finished) begin
      chk(curTag, "busLock", int'(busLock), int'(mLocked));
      chk(curTag, "ownerId", int'(ownerId), int'(mOwner));
      chk(curTag, "lockTimeout", int'(lockTimeout), int'(mTo));
    end
  end

  task automatic drive(input logic [1:0] m, input logic h, input logic w,
                       input logic d, input int id);
    @(negedge clk);
    #1;
    atomMode = m; bankHit = h; isWrite = w; accDone = d; masterId = ID_W'(id);
  endtask

  task automatic idle();
    drive(2'b00, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1 reset state
    chk("R1", "busLock in reset", int'(busLock), 0);
    chk("R1", "ownerId in reset", int'(ownerId), 0);
    chk("R1", "lockTimeout in reset", int'(lockTimeout), 0);
    @(negedge clk); rstN = 1'b1;
    cmpOn = 1'b1;

    // R2 / R3
    curTag = "R2";
    drive(2'b01, 1, 1, 1, 5); idle();
    chk("R2", "lock on write", int'(busLock), 1);
    chk("R2", "owner", int'(ownerId), 5);
    curTag = "R3";
    drive(2'b01, 1, 0, 1, 5); idle();
    chk("R3", "read clears", int'(busLock), 0);

    // R4 / R5
    curTag = "R4";
    drive(2'b10, 1, 0, 1, 9); idle();
    chk("R4", "lock on read", int'(busLock), 1);
    chk("R4", "owner", int'(ownerId), 9);
    curTag = "R5";
    drive(2'b10, 1, 1, 1, 9); idle();
    chk("R5", "write clears", int'(busLock), 0);

    // R6
    curTag = "R6";
    drive(2'b00, 1, 1, 1, 1); drive(2'b00, 1, 0, 1, 1);
    drive(2'b11, 1, 1, 1, 1); drive(2'b11, 1, 0, 1, 1);
    drive(2'b01, 0, 1, 1, 1); drive(2'b10, 1, 0, 0, 1); idle();
    chk("R6", "no lock", int'(busLock), 0);

    // R7
    curTag = "R7";
    drive(2'b10, 1, 0, 1, 1); idle();
    drive(2'b10, 1, 1, 1, 2); idle();
    chk("R7", "other master write", int'(busLock), 1);
    chk("R7", "owner kept", int'(ownerId), 1);
    drive(2'b10, 1, 0, 1, 1); drive(2'b10, 0, 1, 1, 1); idle();
    chk("R7", "owner lock-direction / miss", int'(busLock), 1);
    drive(2'b10, 1, 1, 1, 1); idle();
    chk("R7", "owner clears", int'(busLock), 0);

    // R11
    curTag = "R11";
    drive(2'b01, 1, 1, 1, 3); idle();
    drive(2'b10, 1, 1, 1, 3); idle();
    chk("R11", "write does not clear RAW lock", int'(busLock), 1);
    drive(2'b10, 1, 0, 1, 3); idle();
    chk("R11", "read clears under captured mode", int'(busLock), 0);

    // R8
    curTag = "R8";
    drive(2'b01, 1, 1, 1, 4);
    repeat (WD) idle();
    chk("R8", "held in cycle 256", int'(busLock), 1);
    idle();
    chk("R8", "dropped", int'(busLock), 0);
    chk("R8", "pulse", int'(lockTimeout), 1);
    idle();
    chk("R8", "pulse ends", int'(lockTimeout), 0);

    // R9
    curTag = "R9";
    drive(2'b01, 1, 1, 1, 6);
    repeat (WD - 1) idle();
    drive(2'b01, 1, 0, 1, 6);
    idle();
    chk("R9", "dropped", int'(busLock), 0);
    chk("R9", "no pulse", int'(lockTimeout), 0);

    // R10
    curTag = "R10";
    drive(2'b01, 1, 1, 1, 1);
    repeat (WD - 1) idle();
    drive(2'b01, 1, 1, 1, 2);
    idle();
    chk("R10", "no lock on release cycle", int'(busLock), 0);
    chk("R10", "timeout pulse", int'(lockTimeout), 1);
    drive(2'b01, 1, 1, 1, 2); idle();
    chk("R10", "lock next cycle", int'(busLock), 1);
    chk("R10", "new owner", int'(ownerId), 2);
    drive(2'b01, 1, 0, 1, 2); idle();

    // R1 mid-lock reset
    drive(2'b10, 1, 0, 1, 7); idle();
    @(negedge clk); #1 rstN = 1'b0;
    #1;
    chk("R1", "reset clears lock", int'(busLock), 0);
    chk("R1", "reset clears owner", int'(ownerId), 0);
    @(negedge clk); rstN = 1'b1;

    // random mix
    curTag = "R7";
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] m;
      logic h, w, d;
      int id;
      m  = 2'($urandom_range(0, 3));
      h  = ($urandom_range(0, 9) < 7);
      w  = 1'($urandom_range(0, 1));
      d  = (i % 1500 < 1200) ? ($urandom_range(0, 9) < 6) : 1'b0;
      id = $urandom_range(0, 3);
      drive(m, h, w, d, id);
    end
    idle(); idle();
    finish();
  end

endmodule